// File: doc/BRIEF.md
# RC Time-Constant Calibration Controller

This block is the digital side of a loop that keeps the RC product of a continuous-time filter equal to a reference clock period while process and temperature vary. A scaled replica integrator charges and dumps a capacitor on alternate half-periods of the reference. If the RC product matches the period, the integrator output stays bounded. If it does not match, the output ramps until a comparator reports a crossing of an upper or a lower threshold. The controller owns the 4-bit capacitor trim code that the replica and the main filter cells share. It moves that code one step against each reported drift.

Every code change is followed by a discharge pulse that shorts the integrator's feedback capacitor, so that each observation starts from the same level. After the discharge, a short settle window lets the analog side recover before the comparators are observed again. The controller declares lock in three cases: a long run of half-periods with no crossing, a code pinned at a limit, or a code that oscillates between two neighbouring values. A recalibration request restarts the procedure from the current code. The replica and the comparators sit outside this block.

Top module: `rccal_ctrl`

## Requirements
- R1: While reset is applied, and on leaving it, `cap_code` is 8 (parameter `INIT_CODE`), `int_dump` is 1, and `locked` and `out_of_range` are both 0.
- R2: Every discharge pulse on `int_dump` lasts exactly `DUMP_CYCLES` clocks (default 4). A pulse follows every code step and every recalibration request.
- R3: Comparator inputs are evaluated only in the observe phase. The observe phase starts `SETTLE_CYCLES` clocks (default 2) after a discharge ends. `cmp_hi`=1 lowers the code by one and `cmp_lo`=1 raises it by one. When both are high, `cmp_hi` wins.
- R4: The code saturates at 0 and at 15 and never wraps. A crossing that asks to move past a limit leaves the code unchanged and sets `out_of_range`=1. The controller then discharges once and locks at that limit.
- R5: If `LOCK_TICKS` (default 256) consecutive `phase_tick` pulses arrive in the observe phase with no crossing, `locked` rises and the code is held.
- R6: When the step direction reverses on two consecutive steps, the controller takes the lower of the two codes it is alternating between. It then discharges once and locks with `out_of_range`=0.
- R7: A `recal` pulse clears `locked` and `out_of_range` and clears the direction history. The next cycle starts a discharge pulse, and the code keeps its current value.
- R8: `cap_code` changes only on the clock edge where `int_dump` rises. The code moves by exactly one per change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recal | input | 1 | One-cycle request to restart calibration |
| phase_tick | input | 1 | One-cycle pulse per half-period of the reference |
| cmp_hi | input | 1 | Replica ramp has crossed the upper threshold |
| cmp_lo | input | 1 | Replica ramp has crossed the lower threshold |
| cap_code | output | CODE_W (4) | Capacitor trim code to replica and filter |
| int_dump | output | 1 | Integrator discharge switch enable |
| locked | output | 1 | Calibration finished, code held |
| out_of_range | output | 1 | Calibration ended pinned at a code limit |

## Verification
A behavioural replica in the bench raises one comparator some half-periods after each discharge, chosen from the current code against a programmable window. A window centred on one code gives monotonic convergence upward from reset, then downward after a recalibration, and ends in a quiet lock whose latency is measured. A window that lies above 15 or below 0 drives the code into each saturation limit and separates clamping from wrapping. A window with no quiet code forces an alternating sequence, which tells dither detection apart from endless stepping. Each expected code sequence is rebuilt in the bench from the rules and compared at every discharge pulse.

// File: rtl/rccal_pkg.sv
package rccal_pkg;

  typedef enum logic [2:0] {
    CS_DUMP   = 3'd0,
    CS_SETTLE = 3'd1,
    CS_WATCH  = 3'd2,
    CS_STEP   = 3'd3,
    CS_HOLD   = 3'd4
  } cal_state_e;

  // One unit move of the trim code toward the requested side.
  function automatic int move_code(input int cur, input bit go_down);
    return go_down ? cur - 1 : cur + 1;
  endfunction

  // Lower member of the pair {cur, cur moved one step}.
  function automatic int pair_floor(input int cur, input bit go_down);
    return go_down ? cur - 1 : cur;
  endfunction

endpackage

// File: rtl/rccal_counter.sv
module rccal_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rccal_stepper.sv
module rccal_stepper #(
  parameter int CODE_W    = 4,
  parameter int INIT_CODE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hist_clr,
  input  logic              do_step,
  input  logic              dir_down,
  output logic [CODE_W-1:0] code,
  output logic              sat_hit,
  output logic              finish
);
  import rccal_pkg::*;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic last_valid, last_down, prev_rev;
  logic reversal, dither;
  logic [CODE_W-1:0] code_next;

  assign sat_hit  = dir_down ? (code == '0) : (code == CODE_MAX);
  assign reversal = last_valid && (last_down != dir_down);
  assign dither   = !sat_hit && reversal && prev_rev;
  assign finish   = sat_hit || dither;

  always_comb begin
    if (sat_hit)     code_next = code;
    else if (dither) code_next = CODE_W'(pair_floor(int'(code), dir_down));
    else             code_next = CODE_W'(move_code(int'(code), dir_down));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code       <= CODE_W'(INIT_CODE);
      last_valid <= 1'b0;
      last_down  <= 1'b0;
      prev_rev   <= 1'b0;
    end else if (hist_clr) begin
      last_valid <= 1'b0;
      last_down  <= 1'b0;
      prev_rev   <= 1'b0;
    end else if (do_step) begin
      code       <= code_next;
      last_valid <= 1'b1;
      last_down  <= dir_down;
      prev_rev   <= reversal;
    end
  end

  // R4: a step requested past a limit leaves the code untouched
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && !hist_clr && sat_hit) |=> (code == $past(code)));

  // R8: any code change is a single unit move
  p_unit_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> ((code == $past(code) + 1'b1) || ($past(code) == code + 1'b1)));
endmodule

// File: rtl/rccal_ctrl.sv
module rccal_ctrl #(
  parameter int CODE_W        = 4,
  parameter int INIT_CODE     = 8,
  parameter int DUMP_CYCLES   = 4,
  parameter int SETTLE_CYCLES = 2,
  parameter int LOCK_TICKS    = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recal,
  input  logic              phase_tick,
  input  logic              cmp_hi,
  input  logic              cmp_lo,
  output logic [CODE_W-1:0] cap_code,
  output logic              int_dump,
  output logic              locked,
  output logic              out_of_range
);
  import rccal_pkg::*;

  localparam int WIN_MAX = (DUMP_CYCLES > SETTLE_CYCLES) ? DUMP_CYCLES : SETTLE_CYCLES;
  localparam int CYC_W   = $clog2(WIN_MAX + 1);
  localparam int TCK_W   = $clog2(LOCK_TICKS + 1);
  localparam logic [CYC_W-1:0] DUMP_LAST   = CYC_W'(DUMP_CYCLES - 1);
  localparam logic [CYC_W-1:0] SETTLE_LAST = CYC_W'(SETTLE_CYCLES - 1);
  localparam logic [TCK_W-1:0] QUIET_LAST  = TCK_W'(LOCK_TICKS - 1);

  cal_state_e state_q, state_d;
  logic [CYC_W-1:0] cyc_cnt;
  logic [TCK_W-1:0] tick_cnt;
  logic dir_down_q, pend_lock_q, oor_q;
  logic step_sat, step_finish;

  // Named internal events
  logic dump_done, settle_done, crossing, quiet_done, do_step, cyc_clr;
  assign dump_done   = (state_q == CS_DUMP)   && (cyc_cnt == DUMP_LAST);
  assign settle_done = (state_q == CS_SETTLE) && (cyc_cnt == SETTLE_LAST);
  assign crossing    = (state_q == CS_WATCH)  && (cmp_hi || cmp_lo);
  assign quiet_done  = (state_q == CS_WATCH)  && !crossing && phase_tick && (tick_cnt == QUIET_LAST);
  assign do_step     = (state_q == CS_STEP)   && !recal;
  assign cyc_clr     = (state_q != state_d) || recal;

  rccal_counter #(.W(CYC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(cyc_clr), .inc(1'b1), .cnt(cyc_cnt));

  rccal_counter #(.W(TCK_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(cyc_clr),
    .inc(phase_tick && (state_q == CS_WATCH)), .cnt(tick_cnt));

  rccal_stepper #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_step (
    .clk(clk), .rst_n(rst_n), .hist_clr(recal), .do_step(do_step),
    .dir_down(dir_down_q), .code(cap_code), .sat_hit(step_sat), .finish(step_finish));

  always_comb begin
    state_d = state_q;
    if (recal) state_d = CS_DUMP;
    else begin
      unique case (state_q)
        CS_DUMP:   if (dump_done)   state_d = pend_lock_q ? CS_HOLD : CS_SETTLE;
        CS_SETTLE: if (settle_done) state_d = CS_WATCH;
        CS_WATCH:  if (crossing)    state_d = CS_STEP;
                   else if (quiet_done) state_d = CS_HOLD;
        CS_STEP:   state_d = CS_DUMP;
        CS_HOLD:   state_d = CS_HOLD;
        default:   state_d = CS_DUMP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CS_DUMP;
      dir_down_q  <= 1'b0;
      pend_lock_q <= 1'b0;
      oor_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (crossing && !recal) dir_down_q <= cmp_hi;  // upper crossing has priority
      if (recal) begin
        pend_lock_q <= 1'b0;
        oor_q       <= 1'b0;
      end else if (do_step) begin
        pend_lock_q <= step_finish;
        if (step_sat) oor_q <= 1'b1;
      end
    end
  end

  assign int_dump     = (state_q == CS_DUMP);
  assign locked       = (state_q == CS_HOLD);
  assign out_of_range = oor_q;

  // R2: a discharge pulse never collapses to one cycle
  generate
    if (DUMP_CYCLES >= 2) begin : g_dump_len
      p_dump_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_dump) |=> int_dump);
    end
  endgenerate

  // R8: the code changes only together with the start of a discharge
  p_code_with_dump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_code) |-> int_dump);

  // R7: recalibration drops lock and flag and starts a discharge
  p_recal_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recal |=> (int_dump && !locked && !out_of_range));

  // R4: the range flag only exists on the way to, or in, lock
  p_oor_leads_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range |-> (locked || int_dump));

  // R5: lock is entered from a quiet observation or a finishing discharge
  p_lock_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(quiet_done) || $past(dump_done)));

  // R3: comparators cause a step only from the observe phase
  p_step_from_watch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_STEP) |-> ($past(state_q) == CS_WATCH));
endmodule

// File: tb/rccal_ctrl_bench.sv
module rccal_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recal = 1'b0;
  logic phase_tick = 1'b0;
  logic cmp_hi = 1'b0;
  logic cmp_lo = 1'b0;
  logic [3:0] cap_code;
  logic int_dump, locked, out_of_range;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int up_max = 10;
  int down_min = 12;
  int exp_q[$];
  int last_fall_cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rccal_ctrl u_rccal_ctrl (
    .clk(clk), .rst_n(rst_n), .recal(recal), .phase_tick(phase_tick),
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .cap_code(cap_code),
    .int_dump(int_dump), .locked(locked), .out_of_range(out_of_range));

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Stimulus generator: half-period ticks and a replica/comparator model
  initial begin
    int tk = 0;
    int since = 0;
    forever begin
      @(negedge clk);
      cyc++;
      tk = (tk + 1) % 2;
      phase_tick = (tk == 0);
      if (int_dump) begin
        since = 0; cmp_hi = 1'b0; cmp_lo = 1'b0;
      end else begin
        if (phase_tick) since++;
        if (since == 10 && !cmp_hi && !cmp_lo) begin
          if (int'(cap_code) <= up_max)        cmp_lo = 1'b1;
          else if (int'(cap_code) >= down_min) cmp_hi = 1'b1;
        end
      end
    end
  end

  // Monitor / scoreboard: code at each pulse start, pulse width, code stability
  initial begin
    bit prev_dump = 1'b1;
    bit first = 1'b1;
    int width = 0;
    int held = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (int_dump && !prev_dump) begin
          if (exp_q.size() == 0) check("R3 unexpected pulse", int'(cap_code), -1);
          else check("R3 code at pulse", int'(cap_code), exp_q.pop_front());
          width = 0;
        end
        if (int_dump) width++;
        if (!int_dump && prev_dump) begin
          if (!first) check("R2 pulse width", width, 4);
          first = 1'b0;
          last_fall_cyc = cyc;
          held = int'(cap_code);
        end
        if (!int_dump && !prev_dump && int'(cap_code) != held)
          check("R8 code moved without pulse", int'(cap_code), held);
        prev_dump = int_dump;
      end
    end
  end

  // Driver: rebuild the expected code sequence from the rules
  task automatic plan(input int start, output int fin, output int oor);
    int c = start;
    bit lastv = 0, lastd = 0, prevrev = 0, d, rev;
    oor = 0;
    for (int k = 0; k < 40; k++) begin
      if (c <= up_max) d = 0;
      else if (c >= down_min) d = 1;
      else break;
      rev = lastv && (lastd != d);
      if ((d && c == 0) || (!d && c == 15)) begin oor = 1; exp_q.push_back(c); break; end
      if (rev && prevrev) begin c = d ? c - 1 : c; exp_q.push_back(c); break; end
      c = d ? c - 1 : c + 1;
      exp_q.push_back(c);
      prevrev = rev; lastd = d; lastv = 1;
    end
    fin = c;
  endtask

  task automatic wait_lock(input string req, input int fin, input int oor);
    int t = 0;
    while (!locked && t < 6000) begin @(negedge clk); t++; end
    @(negedge clk);
    check({req, " locked"}, int'(locked), 1);
    check({req, " final code"}, int'(cap_code), fin);
    check({req, " range flag"}, int'(out_of_range), oor);
    check({req, " queue drained"}, exp_q.size(), 0);
  endtask

  task automatic run_recal(input int lo_edge, input int hi_edge, input string req);
    int fin, oor;
    up_max = lo_edge; down_min = hi_edge;
    exp_q.push_back(int'(cap_code));
    plan(int'(cap_code), fin, oor);
    recal = 1'b1;
    @(negedge clk);
    recal = 1'b0;
    check("R7 dump after recal", int'(int_dump), 1);
    check("R7 lock cleared", int'(locked), 0);
    check("R7 flag cleared", int'(out_of_range), 0);
    wait_lock(req, fin, oor);
  endtask

  initial begin
    int fin, oor, lat;
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(cap_code), 8);
    check("R1 reset dump", int'(int_dump), 1);
    check("R1 reset locked", int'(locked), 0);
    check("R1 reset flag", int'(out_of_range), 0);
    plan(8, fin, oor);
    rst_n = 1'b1;
    begin
      int t = 0;
      while (!locked && t < 6000) begin @(negedge clk); t++; end
    end
    lat = cyc - last_fall_cyc;
    check("R5 quiet latency in range", int'(lat >= 512 && lat <= 518), 1);
    check("R5 locked", int'(locked), 1);
    check("R3 upward convergence", int'(cap_code), fin);
    check("R5 no flag", int'(out_of_range), 0);
    repeat (50) @(negedge clk);
    check("R5 code held in lock", int'(cap_code), fin);
    run_recal(2, 4, "R3 downward");
    run_recal(15, 16, "R4 top limit");
    run_recal(5, 6, "R6 dither");
    run_recal(-1, 0, "R4 bottom limit");
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 100000) @(negedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule